// File: doc/BRIEF.md
# Periodic Reload Tick Timer

This block is a system tick timer. It holds a 24-bit count that steps down by one on each selected tick. When the count is at zero, the next tick copies in a programmed reload value. The count therefore wraps around every reload+1 ticks. Each step from one to zero can raise a single-cycle interrupt request. The same step also sets a sticky flag that software can poll.

Software drives the block through a small single-cycle register port. The port has three words: control/status, reload and current count. Read data is combinational and follows the address. The tick is either every core clock cycle or a one-cycle enable that a free-running divide-by-8 prescaler produces. A control bit picks between the two. No clock is gated; every register runs on the core clock, with clock enables.

Top module: `systick_timer`

## Requirements
- R1: After reset, the control, reload and current words all read as zero, and `irq_o` and `cnt_flag_o` are low.
- R2: While the run bit (control bit 0) is set, the count drops by exactly one per tick when it is non-zero. While the run bit is clear, the count holds its value.
- R3: With the source bit (control bit 2) set, every core cycle is a tick. With it clear, a tick occurs once every 8 core cycles. The 3-bit prescaler restarts from zero whenever the run bit is low, so the first slow tick comes 8 cycles after the run bit takes effect.
- R4: A tick at count zero loads the reload value, so events repeat every reload+1 ticks.
- R5: When the interrupt-enable bit (control bit 1) is set, `irq_o` is high for exactly one cycle: the cycle in which the count has just stepped from one to zero. `irq_o` stays low while the interrupt-enable bit is clear.
- R6: The reload word keeps only bits 23:0 of the written data and reads back with bits 31:24 as zero, so the largest period is 2^24 ticks.
- R7: Any write to the current word (address 2) sets the count to zero and clears the sticky flag, whatever the write data. This write takes priority over a tick in the same cycle.
- R8: The sticky flag (control bit 16, also `cnt_flag_o`) is set by every step from one to zero. It is cleared by a read of the control word. A set and a clear in the same cycle leave the flag set. Writes to the control word do not change the flag.
- R9: With reload zero and the count at zero, the count stays at zero and no event is raised.
- R10: Addresses 0, 1 and 2 select the control, reload and current words. Address 3 reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_rd | input | 1 | Read strobe (a read of the control word clears the flag) |
| reg_addr | input | 2 | Word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word, combinational |
| irq_o | output | 1 | One-cycle interrupt request |
| cnt_flag_o | output | 1 | Sticky count flag |

## Verification
The assertions assume that `reg_wr` and `reg_rd` never rise in the same cycle. They also assume that every strobe is a single-cycle access to one word, and that reset is applied before any access. The random stimulus draws exactly one operation per cycle: idle, one write or one read. It never overlaps strobes. Reload values are drawn mostly small, so that many wrap-arounds and slow-source periods happen within the run. A few extreme values are added as directed cases.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_LOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_CUR  = 2'd2;

  localparam int B_RUN  = 0;
  localparam int B_IE   = 1;
  localparam int B_SRC  = 2;
  localparam int B_FLAG = 16;

  typedef struct packed {
    logic src;
    logic ie;
    logic run;
  } ctl_t;
endpackage

// File: rtl/tick_presc.sv
module tick_presc #(
  parameter int PW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic strobe
);
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = run ? cnt_q + 1'b1 : '0;
    strobe = run && (cnt_q == {PW{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRESC_GAP:  assert property (@(posedge clk) disable iff (!rst_n) strobe |=> !strobe); // R3
  AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !run |=> !strobe);   // R3
endmodule

// File: rtl/tick_count.sv
module tick_count #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clear,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cur,
  output logic          zero_evt
);
  logic [CW-1:0] cur_q, cur_d;

  always_comb begin
    cur_d    = cur_q;
    zero_evt = 1'b0;
    if (clear) begin
      cur_d = '0;
    end else if (tick) begin
      if (cur_q == '0) begin
        cur_d = reload;
      end else begin
        cur_d    = cur_q - 1'b1;
        zero_evt = (cur_q == {{(CW-1){1'b0}}, 1'b1});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  assign cur = cur_q;

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && cur != '0) |=> (cur == $past(cur) - 1'b1));        // R2
  AST_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(cur));                                  // R2
  AST_RELOAD:  assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && cur == '0) |=> (cur == $past(reload)));            // R4
endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o,
  output logic        cnt_flag_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] ld_q, ld_d;
  logic             flag_q, flag_d;
  logic             irq_q, irq_d;
  logic             slow_tick, tick, evt;
  logic [CNT_W-1:0] cur;
  logic             wr_ctl, wr_ld, wr_cur, rd_ctl;

  assign wr_ctl = reg_wr && (reg_addr == A_CTRL);
  assign wr_ld  = reg_wr && (reg_addr == A_LOAD);
  assign wr_cur = reg_wr && (reg_addr == A_CUR);
  assign rd_ctl = reg_rd && (reg_addr == A_CTRL);

  tick_presc #(.PW(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_i), .run(ctl_q.run), .strobe(slow_tick)
  );

  assign tick = ctl_q.run && (ctl_q.src || slow_tick);

  tick_count #(.CW(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_i), .tick(tick), .clear(wr_cur),
    .reload(ld_q), .cur(cur), .zero_evt(evt)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d.run = reg_wdata[B_RUN];
      ctl_d.ie  = reg_wdata[B_IE];
      ctl_d.src = reg_wdata[B_SRC];
    end
    ld_d = wr_ld ? reg_wdata[CNT_W-1:0] : ld_q;
    if (wr_cur)      flag_d = 1'b0;
    else if (evt)    flag_d = 1'b1;
    else if (rd_ctl) flag_d = 1'b0;
    else             flag_d = flag_q;
    irq_d = evt && ctl_q.ie;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctl_q  <= '0;
      ld_q   <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      ld_q   <= ld_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_RUN]  = ctl_q.run;
        reg_rdata[B_IE]   = ctl_q.ie;
        reg_rdata[B_SRC]  = ctl_q.src;
        reg_rdata[B_FLAG] = flag_q;
      end
      A_LOAD:  reg_rdata = {{PAD_W{1'b0}}, ld_q};
      A_CUR:   reg_rdata = {{PAD_W{1'b0}}, cur};
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o      = irq_q;
  assign cnt_flag_o = flag_q;

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_i) irq_q |-> (cur == '0));   // R5
  AST_IRQ_PULSE:   assert property (@(posedge clk) disable iff (!rst_i) irq_q |=> !irq_q);        // R5
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_i)
    (!ctl_q.ie) |=> !irq_q);                                                                     // R5
  AST_IRQ_FLAG:    assert property (@(posedge clk) disable iff (!rst_i) irq_q |-> flag_q);        // R8
  AST_CUR_CLEAR:   assert property (@(posedge clk) disable iff (!rst_i)
    wr_cur |=> (cur == '0 && !flag_q));                                                          // R7
  AST_ZERO_LOAD:   assert property (@(posedge clk) disable iff (!rst_i)
    (ld_q == '0 && cur == '0) |=> (cur == '0 && !irq_q));                                        // R9
  AST_NO_OVERLAP:  assert property (@(posedge clk) disable iff (!rst_i) !(reg_wr && reg_rd));     // R10
endmodule

// File: tb/systick_timer_bench.sv
`timescale 1ns/1ps
module systick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o, cnt_flag_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  bit        m_run, m_ie, m_src, m_flag, m_irq;
  bit [23:0] m_ld, m_cur;
  bit [2:0]  m_p;

  always #2.5 clk = ~clk;

  systick_timer u_systick_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .cnt_flag_o(cnt_flag_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    logic [31:0] v = '0;
    case (a)
      2'd0: begin v[0] = m_run; v[1] = m_ie; v[2] = m_src; v[16] = m_flag; end
      2'd1: v = {8'h0, m_ld};
      2'd2: v = {8'h0, m_cur};
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model(input bit wr, input bit rd, input logic [1:0] a, input logic [31:0] d);
    bit tk, ev;
    tk = m_run && (m_src || m_p == 3'd7);
    ev = 0;
    if (wr && a == 2'd2) m_cur = '0;
    else if (tk) begin
      if (m_cur == 0) m_cur = m_ld;
      else begin m_cur = m_cur - 1; ev = (m_cur == 0); end
    end
    m_irq = ev && m_ie;
    if (wr && a == 2'd2)      m_flag = 0;
    else if (ev)              m_flag = 1;
    else if (rd && a == 2'd0) m_flag = 0;
    m_p = m_run ? m_p + 3'd1 : 3'd0;
    if (wr && a == 2'd0) begin m_run = d[0]; m_ie = d[1]; m_src = d[2]; end
    if (wr && a == 2'd1) m_ld = d[23:0];
  endtask

  // one cycle, entered and left at a falling edge
  task automatic step(input bit wr, input bit rd, input logic [1:0] a, input logic [31:0] d);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    #1;
    if (rd) chk("R10 read data", reg_rdata, exp_rd(a));
    @(posedge clk);
    model(wr, rd, a, d);
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
    chk("R5 irq", {31'h0, irq_o}, {31'h0, m_irq});
    chk("R8 flag", {31'h0, cnt_flag_o}, {31'h0, m_flag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'd0, 32'h0);
  endtask

  task automatic wr_w(input logic [1:0] a, input logic [31:0] d); step(1, 0, a, d); endtask

  task automatic rd_w(input logic [1:0] a, input string tag, input logic [31:0] exp);
    reg_rd = 1; reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
    reg_rd = 0;
    step(0, 1, a, 32'h0);
  endtask

  // cycles between two irq pulses
  task automatic period(output int gap);
    int k = 0;
    while (!irq_o && k < 200) begin idle(1); k++; end
    gap = 0;
    do begin idle(1); gap++; end while (!irq_o && gap < 200);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int gap;
    logic [31:0] keep;
    void'($urandom(32'd7021));
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    idle(4);

    // R1 reset state
    rd_w(2'd0, "R1 ctrl after reset", 32'h0);
    rd_w(2'd1, "R1 reload after reset", 32'h0);
    rd_w(2'd2, "R1 count after reset", 32'h0);
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);

    // R4 core source period = reload+1
    wr_w(2'd1, 32'd3);
    wr_w(2'd0, 32'h7);
    period(gap);
    chk("R4 period reload 3 core", gap, 32'd4);

    // R3 slow source period = 8*(reload+1)
    wr_w(2'd0, 32'h3);
    period(gap);
    chk("R3 period reload 3 slow", gap, 32'd32);

    // R3 prescaler restart: first slow tick 8 cycles after run
    wr_w(2'd0, 32'h0);
    wr_w(2'd2, 32'h0);
    wr_w(2'd1, 32'd5);
    wr_w(2'd0, 32'h1);
    idle(7);
    rd_w(2'd2, "R3 no tick before 8 cycles", 32'h0);
    rd_w(2'd2, "R3 first slow tick loads", 32'd5);

    // R7 write to count clears it, data ignored
    wr_w(2'd0, 32'h5);
    idle(3);
    wr_w(2'd2, 32'h0000_0123);
    rd_w(2'd2, "R7 count cleared", 32'h0);

    // R2 hold while stopped
    wr_w(2'd0, 32'h0);
    idle(2);
    keep = exp_rd(2'd2);
    idle(5);
    rd_w(2'd2, "R2 count held when stopped", keep);

    // R6 reload width and max value
    wr_w(2'd1, 32'hFFFF_FFFF);
    rd_w(2'd1, "R6 reload truncated", 32'h00FF_FFFF);
    wr_w(2'd2, 32'h0);
    wr_w(2'd0, 32'h5);
    idle(2);
    rd_w(2'd2, "R6 max reload counting", 32'h00FF_FFFE);

    // R8 flag with interrupts off, cleared by ctrl read
    wr_w(2'd1, 32'd2);
    wr_w(2'd2, 32'h0);
    idle(4);
    chk("R8 flag set without ie", {31'h0, cnt_flag_o}, 32'h1);
    wr_w(2'd0, 32'h0);
    rd_w(2'd0, "R8 flag visible in ctrl", 32'h0001_0000);
    rd_w(2'd0, "R8 flag cleared by read", 32'h0);

    // R9 reload zero stays at zero
    wr_w(2'd1, 32'h0);
    wr_w(2'd2, 32'h0);
    wr_w(2'd0, 32'h7);
    idle(40);
    rd_w(2'd2, "R9 count stays zero", 32'h0);
    chk("R9 no flag", {31'h0, cnt_flag_o}, 32'h0);

    // R10 unused address
    wr_w(2'd3, 32'hFFFF_FFFF);
    rd_w(2'd3, "R10 address 3 reads zero", 32'h0);

    // random mix against the reference
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 70)      idle(1);
      else if (op < 78) wr_w(2'd0, {29'h0, 3'($urandom_range(0, 7))});
      else if (op < 84) wr_w(2'd1, ($urandom_range(0, 9) == 0) ? $urandom : 32'($urandom_range(0, 12)));
      else if (op < 87) wr_w(2'd2, $urandom);
      else              step(0, 1, 2'($urandom_range(0, 3)), 32'h0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule